// File: doc/BRIEF.md
# Multiplexed Bus Machine Cycle Sequencer

This block is the timing-and-control engine of an 8-bit processor whose low address byte and data byte share one set of pins. The processor core hands it one request per machine cycle: an opcode fetch, an operand fetch, a data read or a data write, with an I/O flag and a flag that marks the last cycle of an instruction. The sequencer then runs the cycle as a series of clock-wide states (T1, T2, optional waits, T3 and, for opcode fetches only, T4). It drives the high address byte, the shared low byte, an address strobe, active-low read and write strobes, a memory-or-I/O select and a two-bit status code. When the cycle ends it returns read data to the core with a one-cycle done pulse.

Fetch addresses come from a program counter held inside the sequencer. The counter clears on reset and advances by one each time a fetch is accepted. Reads and writes use the address the core supplies. A slow device stretches a transfer by holding the ready input low. An external bus master can take the bus with a hold request. The sequencer grants it only between instructions, and while it is granted all pin drivers are turned off through their output-enable outputs.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is applied, reset_out_o is 1, status is 00 and both strobes are high. reset_out_o falls at the first clock edge after release. The first opcode fetch after reset uses address 0x0000.
- R2: Every machine cycle begins with one T1 state in which ale_o is high for exactly one clock. In that state addr_hi_o carries address bits 15..8, ad_o carries bits 7..0 with ad_oe_o high, and io_sel_o and status_o already hold their values for the cycle.
- R3: In a read-type cycle rd_n_o is low in T2, in each wait state and in T3, and ad_oe_o is low from T2 on. ad_i is captured at the end of T3 and appears on rsp_data_o with rsp_done_o high in the next clock.
- R4: An opcode fetch (kind 00) uses the program counter as its address and has status 11. It adds a fourth state after T3 in which both strobes are high, ad_oe_o is low and status stays 11. The counter advances by one for each accepted fetch.
- R5: An operand fetch (kind 01) uses the program counter, has status 10 and ends after T3 with no fourth state.
- R6: A write (kind 11) has status 01. wr_n_o is low in T2, the waits and T3, and ad_o carries the write data with ad_oe_o high from T2 on. rd_n_o stays high.
- R7: ready_i is sampled at the end of T2 and of each wait state. Each sample taken low adds one wait state, with the strobes held.
- R8: io_sel_o is 1 for a read (kind 10) or write (kind 11) whose req_io_i was 1. It is 0 for both fetch kinds whatever req_io_i is.
- R9: A hold request is granted only when the sequencer is idle or finishing a cycle and the last finished cycle carried req_last_i (or no cycle has run since reset). While holda_o is 1, addr_hi_oe_o, ad_oe_o and ctl_oe_o are 0, status is 00 and no request is accepted. Outside that window a hold request has no effect on cycles.
- R10: holda_o falls one clock after hold_i is sampled low, and requests are accepted again from then on.
- R11: A request is accepted (req_accept_o high) while the sequencer is idle or in the final state of a cycle. A request accepted in the final state starts its T1 in the very next clock.

Status codes: 00 idle, 01 write, 10 read, 11 opcode fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Core has a machine cycle request |
| req_kind_i | input | 2 | 00 opcode fetch, 01 operand fetch, 10 read, 11 write |
| req_io_i | input | 1 | Read or write targets I/O space |
| req_last_i | input | 1 | This cycle ends an instruction |
| req_addr_i | input | 16 | Address for read or write |
| req_wdata_i | input | 8 | Write data |
| req_accept_o | output | 1 | Request taken this clock |
| rsp_done_o | output | 1 | One-clock pulse after T3 |
| rsp_data_o | output | 8 | Data captured at end of T3 |
| addr_hi_o | output | 8 | Address bits 15..8 |
| addr_hi_oe_o | output | 1 | Drive enable for addr_hi_o |
| ad_o | output | 8 | Shared low address / data out |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 8 | Shared low byte as seen on the pins |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_sel_o | output | 1 | 1 for I/O, 0 for memory |
| status_o | output | 2 | Cycle status code |
| ctl_oe_o | output | 1 | Drive enable for strobes, select and status |
| ready_i | input | 1 | Device ready; low inserts waits |
| hold_i | input | 1 | External master asks for the bus |
| holda_o | output | 1 | Bus released to external master |
| reset_out_o | output | 1 | Reset indication to the system |

## Verification
The sequencer is driven with each of the four cycle kinds, and the pins are checked state by state. This separates the four-state opcode fetch from the three-state operand fetch and separates read strobing from write strobing. A read is stretched by a known number of low ready samples, which shows that each low sample adds exactly one state. An output-instruction sequence (opcode fetch, port-byte fetch, I/O write) and back-to-back writes confirm the program counter stepping, the I/O select and the zero-gap start of a second cycle. Hold is raised once at an instruction boundary and once mid-instruction, which separates an immediate grant from a grant deferred to the end of the instruction.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bst_e;

  typedef enum logic [1:0] {
    K_OPFETCH = 2'd0,
    K_OPERAND = 2'd1,
    K_READ    = 2'd2,
    K_WRITE   = 2'd3
  } kind_e;

  localparam logic [1:0] STAT_IDLE  = 2'b00;
  localparam logic [1:0] STAT_WRITE = 2'b01;
  localparam logic [1:0] STAT_READ  = 2'b10;
  localparam logic [1:0] STAT_FETCH = 2'b11;

  function automatic logic [1:0] status_of(kind_e k);
    case (k)
      K_OPFETCH: return STAT_FETCH;
      K_WRITE:   return STAT_WRITE;
      default:   return STAT_READ;
    endcase
  endfunction

  function automatic logic is_read(kind_e k);
    return k != K_WRITE;
  endfunction

  function automatic logic uses_pc(kind_e k);
    return (k == K_OPFETCH) || (k == K_OPERAND);
  endfunction

  function automatic logic has_decode_state(kind_e k);
    return k == K_OPFETCH;
  endfunction

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_io,
  input  logic              req_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready_i,
  input  logic              hold_i,
  output bst_e              state,
  output kind_e             cur_kind,
  output logic              cur_io,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              req_accept,
  output logic              samp_ready,
  output logic              hold_grant,
  output logic              cycle_end
);

  bst_e              st_q, st_d;
  kind_e             kind_q;
  logic              io_q, last_q, bnd_q, bnd_now, dispatch;
  logic [ADDR_W-1:0] pc_q, addr_q;
  logic [DATA_W-1:0] wdata_q;
  kind_e             in_kind;

  assign in_kind = kind_e'(req_kind);

  always_comb begin
    cycle_end  = ((st_q == ST_T3) && !has_decode_state(kind_q)) || (st_q == ST_T4);
    dispatch   = (st_q == ST_IDLE) || cycle_end;
    bnd_now    = cycle_end ? last_q : bnd_q;
    hold_grant = dispatch && hold_i && bnd_now;
    req_accept = dispatch && req_valid && !hold_grant;
    samp_ready = (st_q == ST_T2) || (st_q == ST_TW);
  end

  always_comb begin
    st_d = st_q;
    if (hold_grant)      st_d = ST_HOLD;
    else if (req_accept) st_d = ST_T1;
    else if (cycle_end)  st_d = ST_IDLE;
    else begin
      case (st_q)
        ST_T1:   st_d = ST_T2;
        ST_T2,
        ST_TW:   st_d = ready_i ? ST_T3 : ST_TW;
        ST_T3:   st_d = ST_T4;
        ST_HOLD: st_d = hold_i ? ST_HOLD : ST_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_OPFETCH;
      io_q    <= 1'b0;
      last_q  <= 1'b0;
      bnd_q   <= 1'b1;
      pc_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (cycle_end) bnd_q <= last_q;
      if (req_accept) begin
        kind_q  <= in_kind;
        io_q    <= uses_pc(in_kind) ? 1'b0 : req_io;
        last_q  <= req_last;
        addr_q  <= uses_pc(in_kind) ? pc_q : req_addr;
        wdata_q <= req_wdata;
        if (uses_pc(in_kind)) pc_q <= pc_q + ADDR_W'(1);
      end
    end
  end

  assign state     = st_q;
  assign cur_kind  = kind_q;
  assign cur_io    = io_q;
  assign cur_addr  = addr_q;
  assign cur_wdata = wdata_q;

endmodule

// File: rtl/bcs_pins.sv
module bcs_pins
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  bst_e                     state,
  input  kind_e                    cur_kind,
  input  logic                     cur_io,
  input  logic [ADDR_W-1:0]        cur_addr,
  input  logic [DATA_W-1:0]        cur_wdata,
  output logic                     ale,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     addr_hi_oe,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_sel,
  output logic [1:0]               status,
  output logic                     ctl_oe,
  output logic                     holda
);

  always_comb begin
    ale        = 1'b0;
    addr_hi    = cur_addr[ADDR_W-1:DATA_W];
    addr_hi_oe = 1'b1;
    ad_o       = cur_addr[DATA_W-1:0];
    ad_oe      = 1'b0;
    rd_n       = 1'b1;
    wr_n       = 1'b1;
    io_sel     = 1'b0;
    status     = STAT_IDLE;
    ctl_oe     = 1'b1;
    holda      = 1'b0;
    case (state)
      ST_T1: begin
        ale    = 1'b1;
        ad_oe  = 1'b1;
        io_sel = cur_io;
        status = status_of(cur_kind);
      end
      ST_T2, ST_TW, ST_T3: begin
        io_sel = cur_io;
        status = status_of(cur_kind);
        if (is_read(cur_kind)) begin
          rd_n = 1'b0;
        end else begin
          wr_n  = 1'b0;
          ad_o  = cur_wdata;
          ad_oe = 1'b1;
        end
      end
      ST_T4: begin
        io_sel = cur_io;
        status = status_of(cur_kind);
      end
      ST_HOLD: begin
        addr_hi_oe = 1'b0;
        ctl_oe     = 1'b0;
        holda      = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/bcs_resp.sv
module bcs_resp
  import bcs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bst_e              state,
  input  kind_e             cur_kind,
  input  logic [DATA_W-1:0] ad_i,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              reset_out
);

  logic cap_en;
  assign cap_en = (state == ST_T3) && is_read(cur_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      rdata     <= '0;
      reset_out <= 1'b1;
    end else begin
      reset_out <= 1'b0;
      done      <= (state == ST_T3);
      if (cap_en) rdata <= ad_i;
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_io_i,
  input  logic              req_last_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_accept_o,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              addr_hi_oe_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              io_sel_o,
  output logic [1:0]        status_o,
  output logic              ctl_oe_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              holda_o,
  output logic              reset_out_o
);

  bst_e              state;
  kind_e             cur_kind;
  logic              cur_io;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              samp_ready;
  logic              hold_grant;
  logic              cycle_end;

  bcs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid_i),
    .req_kind   (req_kind_i),
    .req_io     (req_io_i),
    .req_last   (req_last_i),
    .req_addr   (req_addr_i),
    .req_wdata  (req_wdata_i),
    .ready_i    (ready_i),
    .hold_i     (hold_i),
    .state      (state),
    .cur_kind   (cur_kind),
    .cur_io     (cur_io),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .req_accept (req_accept_o),
    .samp_ready (samp_ready),
    .hold_grant (hold_grant),
    .cycle_end  (cycle_end)
  );

  bcs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state      (state),
    .cur_kind   (cur_kind),
    .cur_io     (cur_io),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .ale        (ale_o),
    .addr_hi    (addr_hi_o),
    .addr_hi_oe (addr_hi_oe_o),
    .ad_o       (ad_o),
    .ad_oe      (ad_oe_o),
    .rd_n       (rd_n_o),
    .wr_n       (wr_n_o),
    .io_sel     (io_sel_o),
    .status     (status_o),
    .ctl_oe     (ctl_oe_o),
    .holda      (holda_o)
  );

  bcs_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .cur_kind  (cur_kind),
    .ad_i      (ad_i),
    .done      (rsp_done_o),
    .rdata     (rsp_data_o),
    .reset_out (reset_out_o)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic addr_hi_oe,
  input logic ctl_oe,
  input logic ready_i,
  input logic hold_i,
  input logic holda,
  input logic req_accept,
  input logic samp_ready,
  input logic hold_grant,
  input logic reset_out
);

  p_rstout_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reset_out |=> !reset_out);

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_ale_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && addr_hi_oe && rd_n && wr_n));

  p_rd_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  p_wr_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && rd_n));

  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_ready && !ready_i) |=> (samp_ready && $stable(rd_n) && $stable(wr_n)));

  p_hold_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    holda |-> (!ad_oe && !addr_hi_oe && !ctl_oe && !req_accept));

  p_hold_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda) |-> $past(hold_grant));

  p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (holda && !hold_i) |=> !holda);

endmodule

bind bus_cycle_seq bcs_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ale        (ale_o),
  .rd_n       (rd_n_o),
  .wr_n       (wr_n_o),
  .ad_oe      (ad_oe_o),
  .addr_hi_oe (addr_hi_oe_o),
  .ctl_oe     (ctl_oe_o),
  .ready_i    (ready_i),
  .hold_i     (hold_i),
  .holda      (holda_o),
  .req_accept (req_accept_o),
  .samp_ready (samp_ready),
  .hold_grant (hold_grant),
  .reset_out  (reset_out_o)
);

// File: tb/bus_cycle_seq_tb.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_io = 1'b0;
  logic        req_last = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_accept, rsp_done;
  logic [7:0]  rsp_data, addr_hi, ad_o;
  logic        addr_hi_oe, ad_oe, ale, rd_n, wr_n, io_sel, ctl_oe, holda, reset_out;
  logic [1:0]  status;
  logic [7:0]  ad_i = '0;
  logic        ready = 1'b1;
  logic        hold = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_pc = 16'h0000;

  always #2.5 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_io_i(req_io), .req_last_i(req_last), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_accept_o(req_accept), .rsp_done_o(rsp_done),
    .rsp_data_o(rsp_data), .addr_hi_o(addr_hi), .addr_hi_oe_o(addr_hi_oe),
    .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i), .ale_o(ale), .rd_n_o(rd_n),
    .wr_n_o(wr_n), .io_sel_o(io_sel), .status_o(status), .ctl_oe_o(ctl_oe),
    .ready_i(ready), .hold_i(hold), .holda_o(holda), .reset_out_o(reset_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary_and_end();
  end

  // Presents one request at a negedge; returns at the negedge where T1 is showing.
  task automatic issue(input logic [1:0] k, input logic io, input logic [15:0] a,
                       input logic [7:0] d, input logic last);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_io = io; req_addr = a;
    req_wdata = d; req_last = last;
    #1 chk("R11", "accept when idle", int'(req_accept), 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset_out in reset", int'(reset_out), 1);
    chk("R1", "status in reset", int'(status), 0);
    chk("R1", "strobes in reset", int'({rd_n, wr_n}), 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset_out after release", int'(reset_out), 0);
  endtask

  task automatic t_opfetch();
    issue(2'd0, 1'b1, 16'hFFFF, 8'h00, 1'b0);
    chk("R1", "first fetch addr hi", int'(addr_hi), int'(exp_pc[15:8]));
    chk("R1", "first fetch addr lo", int'(ad_o), int'(exp_pc[7:0]));
    chk("R2", "ale in T1", int'(ale), 1);
    chk("R2", "ad driven in T1", int'(ad_oe), 1);
    chk("R4", "fetch status", int'(status), 3);
    chk("R8", "fetch is memory", int'(io_sel), 0);
    ad_i = 8'h3E;
    @(negedge clk);
    chk("R2", "ale dropped in T2", int'(ale), 0);
    chk("R3", "rd low in T2", int'(rd_n), 0);
    chk("R3", "ad released in T2", int'(ad_oe), 0);
    @(negedge clk);
    chk("R3", "rd low in T3", int'(rd_n), 0);
    @(negedge clk);
    chk("R4", "rd high in T4", int'(rd_n), 1);
    chk("R4", "status held in T4", int'(status), 3);
    chk("R4", "ad off in T4", int'(ad_oe), 0);
    chk("R3", "done after T3", int'(rsp_done), 1);
    chk("R3", "fetched data", int'(rsp_data), 8'h3E);
    @(negedge clk);
    chk("R4", "idle after T4", int'(status), 0);
    exp_pc = exp_pc + 16'd1;
  endtask

  task automatic t_read_wait(input int nwait);
    int cnt = 0;
    issue(2'd2, 1'b0, 16'h4C21, 8'h00, 1'b1);
    chk("R2", "read addr hi", int'(addr_hi), 8'h4C);
    chk("R2", "read addr lo", int'(ad_o), 8'h21);
    chk("R3", "read status", int'(status), 2);
    ready = 1'b0;
    ad_i = 8'h5A;
    forever begin
      @(negedge clk);
      if (rd_n) break;
      cnt++;
      if (cnt == nwait + 1) ready = 1'b1;
      if (cnt > 50) break;
    end
    chk("R7", "read strobe length with waits", cnt, nwait + 2);
    chk("R3", "done after waited read", int'(rsp_done), 1);
    chk("R3", "waited read data", int'(rsp_data), 8'h5A);
  endtask

  task automatic t_write_b2b();
    issue(2'd3, 1'b0, 16'h1234, 8'hA5, 1'b0);
    chk("R6", "write status", int'(status), 1);
    chk("R2", "write addr lo", int'(ad_o), 8'h34);
    @(negedge clk);
    chk("R6", "wr low in T2", int'(wr_n), 0);
    chk("R6", "rd high in write", int'(rd_n), 1);
    chk("R6", "data on ad in T2", int'(ad_o), 8'hA5);
    chk("R6", "ad driven in T2", int'(ad_oe), 1);
    req_valid = 1'b1; req_kind = 2'd3; req_io = 1'b0;
    req_addr = 16'h1235; req_wdata = 8'h5B; req_last = 1'b1;
    #1 chk("R11", "no accept in T2", int'(req_accept), 0);
    @(negedge clk);
    chk("R6", "wr low in T3", int'(wr_n), 0);
    #1 chk("R11", "accept in final state", int'(req_accept), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "back-to-back T1 ale", int'(ale), 1);
    chk("R11", "back-to-back addr", int'(ad_o), 8'h35);
    chk("R6", "first write done", int'(rsp_done), 1);
    @(negedge clk);
    chk("R6", "second write data", int'(ad_o), 8'h5B);
    @(negedge clk);
    @(negedge clk);
    chk("R6", "wr high after write", int'(wr_n), 1);
  endtask

  task automatic t_out_seq();
    issue(2'd0, 1'b0, 16'h0000, 8'h00, 1'b0);
    chk("R4", "out opcode addr", int'({addr_hi, ad_o}), int'(exp_pc));
    ad_i = 8'hD3;
    repeat (4) @(negedge clk);
    exp_pc = exp_pc + 16'd1;
    issue(2'd1, 1'b1, 16'h0000, 8'h00, 1'b0);
    chk("R5", "port byte addr", int'({addr_hi, ad_o}), int'(exp_pc));
    chk("R5", "port byte status", int'(status), 2);
    chk("R8", "operand fetch memory", int'(io_sel), 0);
    ad_i = 8'h7F;
    repeat (3) @(negedge clk);
    chk("R5", "no fourth state", int'(status), 0);
    chk("R5", "port byte done", int'(rsp_done), 1);
    chk("R5", "port byte data", int'(rsp_data), 8'h7F);
    exp_pc = exp_pc + 16'd1;
    issue(2'd3, 1'b1, {rsp_data, rsp_data}, 8'h99, 1'b1);
    chk("R8", "io write select", int'(io_sel), 1);
    chk("R8", "io write status", int'(status), 1);
    chk("R8", "io port addr", int'({addr_hi, ad_o}), 16'h7F7F);
    @(negedge clk);
    chk("R6", "accumulator on bus", int'(ad_o), 8'h99);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_hold_boundary();
    hold = 1'b1;
    @(negedge clk);
    chk("R9", "holda at boundary", int'(holda), 1);
    chk("R9", "bus floated", int'({addr_hi_oe, ad_oe, ctl_oe}), 0);
    chk("R9", "status in hold", int'(status), 0);
    req_valid = 1'b1; req_kind = 2'd0; req_io = 1'b0; req_last = 1'b0;
    #1 chk("R9", "no accept in hold", int'(req_accept), 0);
    @(negedge clk);
    chk("R9", "still held", int'(holda), 1);
    chk("R9", "no ale in hold", int'(ale), 0);
    hold = 1'b0;
    @(negedge clk);
    chk("R10", "holda dropped", int'(holda), 0);
    #1 chk("R10", "accept after release", int'(req_accept), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "cycle after release", int'(ale), 1);
    chk("R10", "cycle addr after release", int'({addr_hi, ad_o}), int'(exp_pc));
    exp_pc = exp_pc + 16'd1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_hold_mid();
    hold = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "no grant mid-instruction", int'(holda), 0);
    end
    issue(2'd2, 1'b1, 16'h00A0, 8'h00, 1'b1);
    chk("R8", "io read select", int'(io_sel), 1);
    chk("R9", "cycle runs under hold", int'(ale), 1);
    repeat (3) @(negedge clk);
    chk("R9", "grant at instruction end", int'(holda), 1);
    chk("R9", "last cycle completed", int'(rsp_done), 1);
    hold = 1'b0;
    @(negedge clk);
    chk("R10", "holda dropped after end", int'(holda), 0);
  endtask

  initial begin
    t_reset();
    t_opfetch();
    t_read_wait(3);
    t_write_b2b();
    t_out_seq();
    t_hold_boundary();
    t_hold_mid();
    repeat (2) @(negedge clk);
    summary_and_end();
  end

endmodule